// File: doc/BRIEF.md
# Video Field Parity Detector

This block tells odd video fields from even ones. A small phase counter advances once for each tick of a step enable that runs at sixteen times the line rate, so one scan line covers sixteen counts. A horizontal restart pulse puts the counter back to zero. The counter is compared with a 4-bit window value that software writes. When the two are equal, a window signal goes low. It stays low for half a line, which is eight steps, and then goes high again.

The vertical sync input is registered, and its rising edge is found inside the block. At each such edge the field flag takes the current level of the window. A high window marks the field as odd and a low window marks it as even. In normal use the window value is chosen so that the vertical sync edge of one field falls inside the low half-line and the edge of the other field falls outside it.

Top module: `field_parity_detector`

## Requirements
- R1: A clock edge with `rst_n` low sets `win_o` to 1, `field_odd_o` to 0, the phase count to 0 and the stored window value to 0.
- R2: The phase count is 4 bits wide. It goes up by one on each cycle with `step_en` high and wraps from 15 to 0. It holds its value on cycles with `step_en` low.
- R3: `hrestart` high forces the phase count to 0 at the next edge, and it takes priority over `step_en`.
- R4: On a cycle with `step_en` high, if the phase count before that step equals the stored window value, `win_o` is 0 after the edge.
- R5: Once cleared, `win_o` returns to 1 at the eighth later step that is not itself a match. `win_o` changes only on step cycles.
- R6: If a match and the eighth step of a countdown happen on the same step, the match wins: `win_o` stays 0 and the eight-step countdown starts again.
- R7: A cycle with `wr_en` high loads `wr_data[3:0]` into the window value, which is used by later comparisons. A write does not shorten or restart a countdown that is already running.
- R8: A rising edge of `vsync_in` sampled while `win_o` is 1 sets `field_odd_o` to 1 (odd field).
- R9: A rising edge of `vsync_in` sampled while `win_o` is 0 clears `field_odd_o` to 0 (even field).
- R10: `field_odd_o` changes only at the second clock edge after `vsync_in` is first sampled high, and it takes the `win_o` value that is present just before that edge. A falling edge or a steady level of `vsync_in` leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Phase step enable at 16 times the line rate |
| hrestart | input | 1 | Horizontal restart, clears the phase count |
| vsync_in | input | 1 | Vertical sync level |
| wr_en | input | 1 | Window value write strobe |
| wr_data | input | 4 | Window value to store |
| win_o | output | 1 | Field detection window, low for half a line after a match |
| field_odd_o | output | 1 | Field flag, 1 for odd and 0 for even |

## Verification
If the phase count slips or the stored window value is wrong, the low stretch of `win_o` appears at the wrong step. This shows on the first match after the error, which comes within sixteen steps. If the countdown is wrong, the low stretch has the wrong length, and this is visible before the ninth step after a match. Faults in edge detection or in the sampling delay show on `field_odd_o` at the first vertical sync rising edge whose window level differs from the flag's current value.

// File: rtl/fpd_pkg.sv
// Shared constants for the field parity detector.
// Assumes a line spans 2**FPD_PHASE_W phase steps.
package fpd_pkg;
    localparam int FPD_PHASE_W    = 4;
    localparam int FPD_HALF_STEPS = (1 << FPD_PHASE_W) / 2;
endpackage

// File: rtl/fpd_phase_counter.sv
// Horizontal phase counter: steps on step_en, wraps naturally,
// cleared by hrestart (which has priority). Assumes sync active-low reset.
module fpd_phase_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic         hrestart,
    output logic [W-1:0] phase
);
    localparam logic [W-1:0] ONE = W'(1);

    // Advance, restart or hold the phase count.
    always_ff @(posedge clk) begin
        if (!rst_n)        phase <= '0;
        else if (hrestart) phase <= '0;
        else if (step_en)  phase <= phase + ONE;
    end
endmodule

// File: rtl/fpd_window_gen.sv
// Window generator: on each step, compare the pre-step phase with the
// stored value; a match drops the window and loads a HALF-step countdown,
// which raises the window when it expires. The match wins over the expiry.
// Assumes HALF >= 1.
module fpd_window_gen #(
    parameter int W    = 4,
    parameter int HALF = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic [W-1:0] phase,
    input  logic [W-1:0] win_val,
    output logic         win
);
    localparam int RW = $clog2(HALF + 1);
    localparam logic [RW-1:0] RLOAD = RW'(HALF);
    localparam logic [RW-1:0] RONE  = RW'(1);

    logic [RW-1:0] remain;
    logic          hit;

    // Match detection against the stored window value.
    always_comb hit = (phase == win_val);

    // Window level and countdown, advanced only on steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win    <= 1'b1;
            remain <= '0;
        end else if (step_en) begin
            if (hit) begin
                win    <= 1'b0;
                remain <= RLOAD;
            end else if (!win) begin
                if (remain == RONE) begin
                    win    <= 1'b1;
                    remain <= '0;
                end else begin
                    remain <= remain - RONE;
                end
            end
        end
    end
endmodule

// File: rtl/fpd_vsync_flag.sv
// Vertical sync edge sampler: registers vsync twice, detects the rising
// edge and loads the window level into the field flag one clock later.
// Assumes vsync_in is already synchronous to clk.
module fpd_vsync_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_in,
    input  logic win,
    output logic edge_det,
    output logic field_odd
);
    logic vs_q, vs_qq;

    // Two-stage history of the vsync level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q  <= 1'b0;
            vs_qq <= 1'b0;
        end else begin
            vs_q  <= vsync_in;
            vs_qq <= vs_q;
        end
    end

    // Rising edge seen between the two history stages.
    always_comb edge_det = vs_q & ~vs_qq;

    // Field flag captures the window level at a detected edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        field_odd <= 1'b0;
        else if (edge_det) field_odd <= win;
    end
endmodule

// File: rtl/field_parity_detector.sv
// Top of the field parity detector: window register, phase counter,
// window generator and vsync flag stage. Assumes all inputs are synchronous.
module field_parity_detector #(
    parameter int PHASE_W    = fpd_pkg::FPD_PHASE_W,
    parameter int HALF_STEPS = fpd_pkg::FPD_HALF_STEPS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en,
    input  logic               hrestart,
    input  logic               vsync_in,
    input  logic               wr_en,
    input  logic [PHASE_W-1:0] wr_data,
    output logic               win_o,
    output logic               field_odd_o
);
    logic [PHASE_W-1:0] phase;
    logic [PHASE_W-1:0] win_val;
    logic               edge_det;

    // Software-written window value.
    always_ff @(posedge clk) begin
        if (!rst_n)     win_val <= '0;
        else if (wr_en) win_val <= wr_data;
    end

    fpd_phase_counter #(.W(PHASE_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .step_en(step_en),
        .hrestart(hrestart), .phase(phase)
    );

    fpd_window_gen #(.W(PHASE_W), .HALF(HALF_STEPS)) u_window (
        .clk(clk), .rst_n(rst_n), .step_en(step_en),
        .phase(phase), .win_val(win_val), .win(win_o)
    );

    fpd_vsync_flag u_flag (
        .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .win(win_o),
        .edge_det(edge_det), .field_odd(field_odd_o)
    );
endmodule

// File: rtl/fpd_checker.sv
// Property checker for field_parity_detector, attached by bind.
module fpd_checker #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         step_en,
    input logic         hrestart,
    input logic [W-1:0] phase,
    input logic [W-1:0] win_val,
    input logic         edge_det,
    input logic         win_o,
    input logic         field_odd_o
);
    localparam logic [W-1:0] ONE = W'(1);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (win_o && !field_odd_o && phase == '0));

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && step_en && !hrestart) |=> phase == ($past(phase) + ONE));

    // R3
    phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && hrestart) |=> phase == '0);

    // R4
    match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && step_en && phase == win_val) |=> !win_o);

    // R5
    win_only_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !step_en) |=> $stable(win_o));

    // R10
    flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && edge_det) |=> field_odd_o == $past(win_o));

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !edge_det) |=> $stable(field_odd_o));
endmodule

bind field_parity_detector fpd_checker #(.W(PHASE_W)) i_fpd_checker (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .hrestart(hrestart),
    .phase(phase), .win_val(win_val), .edge_det(edge_det),
    .win_o(win_o), .field_odd_o(field_odd_o)
);

// File: tb/test_field_parity_detector.sv
`timescale 1ns/1ps
module test_field_parity_detector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_en = 1'b0, hrestart = 1'b0, vsync_in = 1'b0, wr_en = 1'b0;
    logic [3:0] wr_data = 4'd0;
    logic       win_o, field_odd_o;
    int         vectors = 0, fails = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    field_parity_detector i_field_parity_detector (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .hrestart(hrestart),
        .vsync_in(vsync_in), .wr_en(wr_en), .wr_data(wr_data),
        .win_o(win_o), .field_odd_o(field_odd_o)
    );

    // Reference state built from the requirements.
    logic [3:0] m_cnt, m_val, m_rem;
    logic       m_win, m_flag, m_q1, m_q2;

    function automatic logic [3:0] f_next_cnt(logic [3:0] c, logic st, logic hr);
        if (hr) return 4'd0;        // R3
        if (st) return c + 4'd1;    // R2
        return c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_val <= 0; m_rem <= 0;
            m_win <= 1; m_flag <= 0; m_q1 <= 0; m_q2 <= 0;
        end else begin
            m_q1 <= vsync_in; m_q2 <= m_q1;
            if (m_q1 && !m_q2) m_flag <= m_win;   // R8 R9 R10
            if (wr_en) m_val <= wr_data;          // R7
            m_cnt <= f_next_cnt(m_cnt, step_en, hrestart);
            if (step_en) begin
                if (m_cnt == m_val) begin m_win <= 0; m_rem <= 4'd8; end  // R4 R6
                else if (!m_win) begin
                    if (m_rem == 4'd1) begin m_win <= 1; m_rem <= 0; end  // R5
                    else m_rem <= m_rem - 4'd1;
                end
            end
        end
    end

    task automatic check(string tag, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the reference.
    always @(negedge clk) if (rst_n && !done) begin
        check("R4 R5 R6 R7 window", win_o, m_win);
        check("R8 R9 R10 flag", field_odd_o, m_flag);
    end

    task automatic drive(logic st, logic hr, logic we, logic [3:0] wd, logic vs);
        step_en = st; hrestart = hr; wr_en = we; wr_data = wd; vsync_in = vs;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; drive(0, 0, 0, 0, 0); drive(0, 0, 0, 0, 0); rst_n = 1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 reset win", win_o, 1'b1);
        check("R1 reset flag", field_odd_o, 1'b0);
        drive(1, 0, 0, 0, 0);
        check("R1 R4 first step matches count 0", win_o, 1'b0);
        for (int i = 0; i < 7; i++) begin
            drive(1, 0, 0, 0, 0);
            check("R5 window held low", win_o, 1'b0);
        end
        drive(0, 0, 0, 0, 0);
        check("R5 no change without step", win_o, 1'b0);
        drive(1, 0, 0, 0, 0);
        check("R5 window back high on 8th step", win_o, 1'b1);
        drive(0, 0, 0, 0, 1);
        check("R10 flag not yet loaded", field_odd_o, 1'b0);
        drive(0, 0, 0, 0, 1);
        check("R8 odd field", field_odd_o, 1'b1);
        for (int i = 0; i < 8; i++) drive(1, 0, 0, 0, 1);   // count 9 -> 0 compared
        check("R2 wrap then match at 0", win_o, 1'b0);
        drive(0, 0, 0, 0, 0);
        check("R10 falling edge ignored", field_odd_o, 1'b1);
        drive(0, 0, 0, 0, 1);
        drive(0, 0, 0, 0, 1);
        check("R9 even field", field_odd_o, 1'b0);

        // R6 collision of match and countdown end.
        do_reset();
        drive(0, 1, 0, 0, 0);
        drive(1, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) drive(1, 0, 0, 0, 0);
        drive(1, 1, 0, 0, 0);
        check("R3 R5 still low before collision", win_o, 1'b0);
        drive(1, 0, 0, 0, 0);
        check("R6 match wins", win_o, 1'b0);
        for (int i = 0; i < 7; i++) drive(1, 0, 0, 0, 0);
        check("R6 countdown restarted", win_o, 1'b0);
        drive(1, 0, 0, 0, 0);
        check("R6 high after restarted countdown", win_o, 1'b1);

        // R7 write during countdown.
        do_reset();
        drive(1, 0, 0, 0, 0);
        drive(0, 0, 1, 4'd12, 0);
        for (int i = 0; i < 7; i++) drive(1, 0, 0, 0, 0);
        check("R7 countdown not cut short", win_o, 1'b0);
        drive(1, 0, 0, 0, 0);
        check("R7 countdown completes", win_o, 1'b1);
        for (int i = 0; i < 3; i++) drive(1, 0, 0, 0, 0);
        check("R7 no match before new value", win_o, 1'b1);
        drive(1, 0, 0, 0, 0);
        check("R7 new value matches", win_o, 1'b0);

        // Constrained random traffic.
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            drive(($urandom % 3) != 0, ($urandom % 23) == 0,
                  ($urandom % 41) == 0, 4'($urandom),
                  ((i / (3 + (i % 5))) % 2) == 1);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule